// File: doc/BRIEF.md
# Interrupt Pin Capture and Delivery Scanner

This block watches a bank of interrupt input pins and keeps one pending bit per pin. A pin that goes high sets its pending bit and asks for a scan. Each pin follows the trigger rule in its own configuration entry. For a level pin, the pending bit drops when the pin drops. For an edge pin, the pending bit is held until a delivery succeeds. A scan walks the pins from the lowest index upward. Each pin that is pending and not masked is turned into one outbound message. The message carries the vector, destination, delivery mode, destination mode, polarity, trigger mode and pin number. The receiver answers with ready and an accept/reject bit. The result updates the pin's delivery status and a count of consecutive refusals.

The configuration entries come from a register front end outside this block and are plain inputs here. Delivery mode 7 means external interrupt. In that mode the block does not use the entry's vector field. Instead it raises an acknowledge request to a legacy interrupt controller, waits for the acknowledge, and sends the vector the controller returns.

The scan state machine has four states:
- `SC_IDLE` waits for a latched request. It then goes to `SC_SEEK` with the pin index at zero.
- `SC_SEEK` looks at one pin per cycle. It goes to `SC_SEND` on a hit with an ordinary mode. It goes to `SC_IACK` on a hit in external mode. It steps to the next pin on a miss. It returns to `SC_IDLE` after the last pin.
- `SC_IACK` holds the acknowledge request until the controller answers, then goes to `SC_SEND`.
- `SC_SEND` holds the message until ready, then returns to `SC_SEEK` at the next pin.

Top module: `irq_scan_top`

## Requirements
- R1: A pin's stored level changes only when the sampled pin differs from it. A pin held high creates no new pending bit and no new scan request.
- R2: On a rising pin, the stored level and the pending bit are both set at the next clock edge, and a scan is requested. This holds for both trigger modes.
- R3: On a falling pin, the stored level clears. The pending bit clears if the pin's trigger mode is level (entry bit = 1). It stays set if the trigger mode is edge (entry bit = 0).
- R4: A scan visits the pins in ascending index order. It delivers only pins that are pending and whose mask bit is 0. A pending pin with mask bit 1 is not delivered and stays pending.
- R5: The message fields are copied from the selected pin's entry, together with the pin index. They stay stable while `msg_valid` is high and `msg_ready` is low.
- R6: When the delivery mode is 7, `iack_req` is raised before the message is sent. `msg_valid` stays low until `iack_ack`. The message vector is then the `iack_vec` value, not the entry's vector.
- R7: On an accepted delivery (`msg_ready` and `msg_accept` both 1), the pin's delivery status clears. The pending bit clears for an edge pin and stays set for a level pin.
- R8: On a rejected delivery (`msg_ready` = 1, `msg_accept` = 0), the pin's delivery status is set and its pending bit stays set.
- R9: Rejections are counted. `stuck` rises when more than 5 consecutive rejections have occurred. Any accepted delivery returns `stuck` to 0.
- R10: A scan request that arrives during a pass is latched. A new pass starts after the current pass ends.
- R11: After reset, the stored levels, pending bits, delivery status bits and `stuck` are all 0, and no message or acknowledge request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Synchronised interrupt pin levels |
| rescan | input | 1 | Scan request from the register front end |
| cfg_vector | input | NUM_PINS x VEC_W | Per-pin vector |
| cfg_dest | input | NUM_PINS x DEST_W | Per-pin destination |
| cfg_dmode | input | NUM_PINS x 3 | Per-pin delivery mode, 7 = external |
| cfg_logical | input | NUM_PINS | Per-pin destination mode |
| cfg_active_low | input | NUM_PINS | Per-pin polarity, passed to the message |
| cfg_level | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| msg_valid | output | 1 | Message held for the receiver |
| msg_ready | input | 1 | Receiver takes the message this cycle |
| msg_accept | input | 1 | Sampled with ready: 1 accepted, 0 refused |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode |
| msg_active_low | output | 1 | Message polarity |
| msg_level | output | 1 | Message trigger mode |
| msg_pin | output | clog2(NUM_PINS) | Index of the delivered pin |
| iack_req | output | 1 | Acknowledge request to the legacy controller |
| iack_ack | input | 1 | Acknowledge returned, vector valid |
| iack_vec | input | VEC_W | Vector from the legacy controller |
| pin_level | output | NUM_PINS | Stored pin levels |
| pending | output | NUM_PINS | Pending bits |
| dlv_status | output | NUM_PINS | Per-pin delivery status, 1 = last try refused |
| stuck | output | 1 | Refusal count above its limit |

## Verification
The trigger-mode checks assume that a pin's trigger-mode bit does not change in the cycle in which that pin falls. The bench meets this by writing every configuration entry at least one cycle before it moves the pin. The message and acknowledge hold checks assume that the receiver and the legacy controller answer only through `msg_ready` and `iack_ack`. The bench raises those inputs only on a negative edge, and only while the matching request is visible. It drops them one cycle later, so each handshake completes exactly once.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;

    // Scan state machine encoding
    typedef enum logic [1:0] {
        SC_IDLE,
        SC_SEEK,
        SC_IACK,
        SC_SEND
    } scan_state_e;

    // Delivery mode that fetches its vector from the legacy controller
    localparam logic [2:0] DM_EXTINT = 3'd7;

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
    parameter int NUM_PINS = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         pin_in,
    input  logic [NUM_PINS-1:0]         cfg_level,
    input  logic                        dlv_fire,
    input  logic                        dlv_ok,
    input  logic                        dlv_edge,
    input  logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] dlv_pin,
    output logic [NUM_PINS-1:0]         pin_level,
    output logic [NUM_PINS-1:0]         pending,
    output logic                        rise_any
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] lvl_q, pend_q;
    logic [NUM_PINS-1:0] changed, rise, fall, clr_dlv, pend_n;

    // Per-pin clear from a successful edge-mode delivery
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_clr
        assign clr_dlv[g] = dlv_fire && dlv_ok && dlv_edge && (dlv_pin == IDX_W'(g));
    end

    always_comb begin
        changed = pin_in ^ lvl_q;
        rise    = changed & pin_in;
        fall    = changed & ~pin_in;
        // A new rising level wins over any clear in the same cycle
        pend_n  = (pend_q & ~(fall & cfg_level) & ~clr_dlv) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= pin_in;
            pend_q <= pend_n;
        end
    end

    assign pin_level = lvl_q;
    assign pending   = pend_q;
    assign rise_any  = |rise;

endmodule

// File: rtl/irq_retry_monitor.sv
module irq_retry_monitor #(
    parameter int NUM_PINS    = 24,
    parameter int STUCK_LIMIT = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dlv_fire,
    input  logic                        dlv_ok,
    input  logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] dlv_pin,
    output logic [NUM_PINS-1:0]         dlv_status,
    output logic                        stuck
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int SAT   = STUCK_LIMIT + 1;
    localparam int CW    = $clog2(SAT + 1);

    logic [CW-1:0]       rej_q;
    logic [NUM_PINS-1:0] stat_q;

    // Consecutive refusal counter, saturating one above the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= '0;
        end else if (dlv_fire) begin
            if (dlv_ok) begin
                rej_q <= '0;
            end else if (rej_q != CW'(SAT)) begin
                rej_q <= rej_q + CW'(1);
            end
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[g] <= 1'b0;
            end else if (dlv_fire && (dlv_pin == IDX_W'(g))) begin
                stat_q[g] <= !dlv_ok;
            end
        end
    end

    assign dlv_status = stat_q;
    assign stuck      = rej_q > CW'(STUCK_LIMIT);

endmodule

// File: rtl/irq_scan_fsm.sv
module irq_scan_fsm
    import irq_scan_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             kick,
    input  logic [NUM_PINS-1:0]              pending,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]   cfg_vector,
    input  logic [NUM_PINS-1:0][DEST_W-1:0]  cfg_dest,
    input  logic [NUM_PINS-1:0][2:0]         cfg_dmode,
    input  logic [NUM_PINS-1:0]              cfg_logical,
    input  logic [NUM_PINS-1:0]              cfg_active_low,
    input  logic [NUM_PINS-1:0]              cfg_level,
    input  logic [NUM_PINS-1:0]              cfg_mask,
    input  logic                             msg_ready,
    input  logic                             msg_accept,
    input  logic                             iack_ack,
    input  logic [VEC_W-1:0]                 iack_vec,
    output logic                             msg_valid,
    output logic [VEC_W-1:0]                 msg_vector,
    output logic [DEST_W-1:0]                msg_dest,
    output logic [2:0]                       msg_dmode,
    output logic                             msg_logical,
    output logic                             msg_active_low,
    output logic                             msg_level,
    output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] msg_pin,
    output logic                             iack_req,
    output logic                             dlv_fire,
    output logic                             dlv_ok
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int CNT_W = $clog2(NUM_PINS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_PINS);

    scan_state_e st_q, st_n;

    logic [CNT_W-1:0]  idx_q;
    logic              req_q;
    logic [IDX_W-1:0]  sel;
    logic              at_end, hit, is_ext;

    logic [VEC_W-1:0]  vec_q;
    logic [DEST_W-1:0] dest_q;
    logic [2:0]        dmode_q;
    logic              logical_q, alow_q, level_q;
    logic [IDX_W-1:0]  pin_q;

    assign sel    = idx_q[IDX_W-1:0];
    assign at_end = (idx_q == LAST);
    assign hit    = !at_end && pending[sel] && !cfg_mask[sel];
    assign is_ext = (cfg_dmode[sel] == DM_EXTINT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SC_IDLE;
        else        st_q <= st_n;
    end

    // Next-state decision
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SC_IDLE: if (req_q)     st_n = SC_SEEK;
            SC_SEEK: begin
                if (at_end)         st_n = SC_IDLE;
                else if (hit)       st_n = is_ext ? SC_IACK : SC_SEND;
            end
            SC_IACK: if (iack_ack)  st_n = SC_SEND;
            SC_SEND: if (msg_ready) st_n = SC_SEEK;
            default:                st_n = SC_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        msg_valid = 1'b0;
        iack_req  = 1'b0;
        dlv_fire  = 1'b0;
        unique case (st_q)
            SC_IDLE: ;
            SC_SEEK: ;
            SC_IACK: iack_req = 1'b1;
            SC_SEND: begin
                msg_valid = 1'b1;
                dlv_fire  = msg_ready;
            end
            default: ;
        endcase
        dlv_ok = msg_accept;
    end

    // Request latch, pin walker and message holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            idx_q     <= '0;
            vec_q     <= '0;
            dest_q    <= '0;
            dmode_q   <= '0;
            logical_q <= 1'b0;
            alow_q    <= 1'b0;
            level_q   <= 1'b0;
            pin_q     <= '0;
        end else begin
            req_q <= (req_q && (st_q != SC_IDLE)) || kick;
            unique case (st_q)
                SC_IDLE: if (req_q) idx_q <= '0;
                SC_SEEK: begin
                    if (hit) begin
                        vec_q     <= cfg_vector[sel];
                        dest_q    <= cfg_dest[sel];
                        dmode_q   <= cfg_dmode[sel];
                        logical_q <= cfg_logical[sel];
                        alow_q    <= cfg_active_low[sel];
                        level_q   <= cfg_level[sel];
                        pin_q     <= sel;
                    end else if (!at_end) begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
                SC_IACK: if (iack_ack) vec_q <= iack_vec;
                SC_SEND: if (msg_ready) idx_q <= idx_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    assign msg_vector     = vec_q;
    assign msg_dest       = dest_q;
    assign msg_dmode      = dmode_q;
    assign msg_logical    = logical_q;
    assign msg_active_low = alow_q;
    assign msg_level      = level_q;
    assign msg_pin        = pin_q;

endmodule

// File: rtl/irq_scan_top.sv
module irq_scan_top #(
    parameter int NUM_PINS    = 24,
    parameter int VEC_W       = 8,
    parameter int DEST_W      = 8,
    parameter int STUCK_LIMIT = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0]              pin_in,
    input  logic                             rescan,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]   cfg_vector,
    input  logic [NUM_PINS-1:0][DEST_W-1:0]  cfg_dest,
    input  logic [NUM_PINS-1:0][2:0]         cfg_dmode,
    input  logic [NUM_PINS-1:0]              cfg_logical,
    input  logic [NUM_PINS-1:0]              cfg_active_low,
    input  logic [NUM_PINS-1:0]              cfg_level,
    input  logic [NUM_PINS-1:0]              cfg_mask,
    output logic                             msg_valid,
    input  logic                             msg_ready,
    input  logic                             msg_accept,
    output logic [VEC_W-1:0]                 msg_vector,
    output logic [DEST_W-1:0]                msg_dest,
    output logic [2:0]                       msg_dmode,
    output logic                             msg_logical,
    output logic                             msg_active_low,
    output logic                             msg_level,
    output logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] msg_pin,
    output logic                             iack_req,
    input  logic                             iack_ack,
    input  logic [VEC_W-1:0]                 iack_vec,
    output logic [NUM_PINS-1:0]              pin_level,
    output logic [NUM_PINS-1:0]              pending,
    output logic [NUM_PINS-1:0]              dlv_status,
    output logic                             stuck
);
    logic rise_any, kick, dlv_fire, dlv_ok;

    assign kick = rescan || rise_any;

    irq_pin_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .cfg_level (cfg_level),
        .dlv_fire  (dlv_fire),
        .dlv_ok    (dlv_ok),
        .dlv_edge  (!msg_level),
        .dlv_pin   (msg_pin),
        .pin_level (pin_level),
        .pending   (pending),
        .rise_any  (rise_any)
    );

    irq_scan_fsm #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .DEST_W   (DEST_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .kick           (kick),
        .pending        (pending),
        .cfg_vector     (cfg_vector),
        .cfg_dest       (cfg_dest),
        .cfg_dmode      (cfg_dmode),
        .cfg_logical    (cfg_logical),
        .cfg_active_low (cfg_active_low),
        .cfg_level      (cfg_level),
        .cfg_mask       (cfg_mask),
        .msg_ready      (msg_ready),
        .msg_accept     (msg_accept),
        .iack_ack       (iack_ack),
        .iack_vec       (iack_vec),
        .msg_valid      (msg_valid),
        .msg_vector     (msg_vector),
        .msg_dest       (msg_dest),
        .msg_dmode      (msg_dmode),
        .msg_logical    (msg_logical),
        .msg_active_low (msg_active_low),
        .msg_level      (msg_level),
        .msg_pin        (msg_pin),
        .iack_req       (iack_req),
        .dlv_fire       (dlv_fire),
        .dlv_ok         (dlv_ok)
    );

    irq_retry_monitor #(
        .NUM_PINS    (NUM_PINS),
        .STUCK_LIMIT (STUCK_LIMIT)
    ) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .dlv_fire   (dlv_fire),
        .dlv_ok     (dlv_ok),
        .dlv_pin    (msg_pin),
        .dlv_status (dlv_status),
        .stuck      (stuck)
    );

endmodule

// File: rtl/irq_scan_chk.sv
module irq_scan_chk #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int DEST_W   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PINS-1:0]         pin_level,
    input logic [NUM_PINS-1:0]         pending,
    input logic [NUM_PINS-1:0]         cfg_level,
    input logic                        msg_valid,
    input logic                        msg_ready,
    input logic                        msg_accept,
    input logic [VEC_W-1:0]            msg_vector,
    input logic [DEST_W-1:0]           msg_dest,
    input logic [((NUM_PINS > 1) ? $clog2(NUM_PINS) : 1)-1:0] msg_pin,
    input logic                        iack_req,
    input logic                        iack_ack,
    input logic [NUM_PINS-1:0]         dlv_status,
    input logic                        stuck
);
    a_r5_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                    && $stable(msg_dest) && $stable(msg_pin));

    a_r6_iack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        iack_req && !iack_ack |=> iack_req);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && iack_req));

    a_r7_accept_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && msg_accept |=> !dlv_status[$past(msg_pin)]);

    a_r8_reject_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && !msg_accept |=> dlv_status[$past(msg_pin)]);

    a_r9_accept_resets_stuck: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && msg_accept |=> !stuck);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        a_r2_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_level[g]) |-> pending[g]);

        a_r3_level_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_level[g]) && $past(cfg_level[g]) |-> !pending[g]);
    end

endmodule

bind irq_scan_top irq_scan_chk #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W),
    .DEST_W   (DEST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_level  (pin_level),
    .pending    (pending),
    .cfg_level  (cfg_level),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_accept (msg_accept),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .msg_pin    (msg_pin),
    .iack_req   (iack_req),
    .iack_ack   (iack_ack),
    .dlv_status (dlv_status),
    .stuck      (stuck)
);

// File: tb/irq_scan_top_test.sv
`timescale 1ns/1ps
module irq_scan_top_test;
    localparam int N = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic rescan = 1'b0;
    logic [N-1:0][7:0] cfg_vector = '0;
    logic [N-1:0][7:0] cfg_dest = '0;
    logic [N-1:0][2:0] cfg_dmode = '0;
    logic [N-1:0] cfg_logical = '0;
    logic [N-1:0] cfg_active_low = '0;
    logic [N-1:0] cfg_level = '0;
    logic [N-1:0] cfg_mask = '1;
    logic msg_ready = 1'b0, msg_accept = 1'b0;
    logic iack_ack = 1'b0;
    logic [7:0] iack_vec = '0;
    logic msg_valid, msg_logical, msg_active_low, msg_level, iack_req, stuck;
    logic [7:0] msg_vector, msg_dest;
    logic [2:0] msg_dmode;
    logic [4:0] msg_pin;
    logic [N-1:0] pin_level, pending, dlv_status;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_scan_top uut (.*);

    typedef struct packed {
        logic [4:0] pin;
        logic       lvl;
        logic       msk;
        logic       acc;
        logic [7:0] vec;
    } row_t;

    localparam row_t ROWS [7] = '{
        '{5'd4,  1'b0, 1'b0, 1'b1, 8'h31},
        '{5'd12, 1'b1, 1'b0, 1'b1, 8'h42},
        '{5'd23, 1'b0, 1'b0, 1'b0, 8'h53},
        '{5'd17, 1'b1, 1'b0, 1'b0, 8'h64},
        '{5'd8,  1'b0, 1'b1, 1'b0, 8'h75},
        '{5'd0,  1'b1, 1'b1, 1'b0, 8'h86},
        '{5'd22, 1'b1, 1'b0, 1'b1, 8'hF0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int n = 0; n < 200; n++) begin
            if (msg_valid) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic respond(input bit acc);
        msg_ready = 1'b1; msg_accept = acc;
        @(negedge clk);
        msg_ready = 1'b0; msg_accept = 1'b0;
    endtask

    task automatic kick_scan();
        @(negedge clk); rescan = 1'b1;
        @(negedge clk); rescan = 1'b0;
    endtask

    task automatic drain();
        cfg_mask = '0;
        kick_scan();
        for (int n = 0; n < 120; n++) begin
            if (msg_valid) respond(1'b1);
            else if (iack_req) begin
                iack_ack = 1'b1; @(negedge clk); iack_ack = 1'b0;
            end else @(negedge clk);
        end
        cfg_mask = '1;
        cfg_dmode = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        pin_in = '0; cfg_mask = '1; cfg_dmode = '0; cfg_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit got;
        logic [7:0] v0;
        do_reset();

        // R11 reset state
        chk(pending == '0 && pin_level == '0, "R11 levels/pending", {pending}, 0);
        chk(dlv_status == '0 && !stuck, "R11 status/stuck", {dlv_status}, 0);
        chk(!msg_valid && !iack_req, "R11 handshakes idle", {msg_valid, iack_req}, 0);

        // Table of single-pin scenarios
        foreach (ROWS[k]) begin
            automatic row_t r = ROWS[k];
            automatic bit exp_pend;
            cfg_vector[r.pin] = r.vec;
            cfg_dest[r.pin]   = 8'(r.pin) + 8'd1;
            cfg_level[r.pin]  = r.lvl;
            cfg_mask[r.pin]   = r.msk;
            @(negedge clk);
            pin_in[r.pin] = 1'b1;
            @(negedge clk);
            chk(pin_level[r.pin] && pending[r.pin], "R2 rise sets level and pending",
                {pin_level[r.pin], pending[r.pin]}, 2'b11);
            if (r.msk) begin
                got = 0;
                for (int n = 0; n < 40; n++) begin
                    if (msg_valid) got = 1;
                    @(negedge clk);
                end
                chk(!got && pending[r.pin], "R4 masked pin kept pending, not sent",
                    {got, pending[r.pin]}, 2'b01);
                exp_pend = 1'b1;
            end else begin
                wait_msg(got);
                chk(got && msg_pin == r.pin && msg_vector == r.vec, "R5 message pin/vector",
                    {msg_pin, msg_vector}, {r.pin, r.vec});
                chk(msg_dest == 8'(r.pin) + 8'd1 && msg_level == r.lvl, "R5 message dest/trigger",
                    {msg_dest, msg_level}, {8'(r.pin) + 8'd1, r.lvl});
                respond(r.acc);
                exp_pend = r.lvl ? 1'b1 : !r.acc;
                chk(pending[r.pin] == exp_pend, r.acc ? "R7 pending after accept" : "R8 pending after reject",
                    pending[r.pin], exp_pend);
                chk(dlv_status[r.pin] == !r.acc, r.acc ? "R7 status cleared" : "R8 status set",
                    dlv_status[r.pin], !r.acc);
            end
            // R1 pin held high: no change, no new delivery
            got = 0;
            for (int n = 0; n < 40; n++) begin
                if (msg_valid) got = 1;
                @(negedge clk);
            end
            chk(!got && pending[r.pin] == exp_pend && pin_level[r.pin], "R1 held pin is quiet",
                {got, pending[r.pin]}, {1'b0, exp_pend});
            pin_in[r.pin] = 1'b0;
            @(negedge clk);
            chk(!pin_level[r.pin] && pending[r.pin] == (r.lvl ? 1'b0 : exp_pend), "R3 fall rule",
                pending[r.pin], r.lvl ? 1'b0 : exp_pend);
            drain();
            cfg_level[r.pin] = 1'b0;
        end

        // R4 ascending order with a masked lower pin skipped
        do_reset();
        cfg_vector[3] = 8'h03; cfg_vector[9] = 8'h09;
        cfg_mask[3] = 1'b0; cfg_mask[9] = 1'b0; cfg_mask[1] = 1'b1;
        @(negedge clk);
        pin_in[1] = 1'b1; pin_in[3] = 1'b1; pin_in[9] = 1'b1;
        wait_msg(got);
        chk(got && msg_pin == 5'd3, "R4 first delivery is lowest unmasked", msg_pin, 3);
        respond(1'b1);
        wait_msg(got);
        chk(got && msg_pin == 5'd9, "R4 second delivery", msg_pin, 9);
        respond(1'b1);
        chk(pending[1] && !pending[3] && !pending[9], "R4 masked pin still pending",
            {pending[9], pending[3], pending[1]}, 3'b001);
        pin_in = '0;
        drain();

        // R6 external mode through the legacy acknowledge
        do_reset();
        cfg_vector[5] = 8'h11; cfg_dmode[5] = 3'd7; cfg_mask[5] = 1'b0;
        @(negedge clk);
        pin_in[5] = 1'b1;
        got = 0;
        for (int n = 0; n < 60 && !got; n++) begin
            if (iack_req) got = 1; else @(negedge clk);
        end
        chk(got && !msg_valid, "R6 acknowledge requested first", {got, msg_valid}, 2'b10);
        repeat (3) @(negedge clk);
        chk(iack_req && !msg_valid, "R6 waits for acknowledge", {iack_req, msg_valid}, 2'b10);
        iack_vec = 8'hA5; iack_ack = 1'b1;
        @(negedge clk);
        iack_ack = 1'b0; iack_vec = 8'h00;
        chk(msg_valid && msg_vector == 8'hA5 && msg_dmode == 3'd7, "R6 vector from controller",
            {msg_valid, msg_vector}, {1'b1, 8'hA5});
        v0 = msg_vector;
        repeat (3) @(negedge clk);
        chk(msg_valid && msg_vector == v0 && msg_pin == 5'd5, "R5 held until ready",
            {msg_valid, msg_vector}, {1'b1, v0});
        respond(1'b1);
        pin_in = '0;
        drain();

        // R9 consecutive refusals
        do_reset();
        cfg_mask[2] = 1'b0;
        @(negedge clk);
        pin_in[2] = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) kick_scan();
            wait_msg(got);
            respond(1'b0);
            chk(stuck == (k > 5), "R9 stuck after refusals", {stuck}, (k > 5));
        end
        kick_scan();
        wait_msg(got);
        respond(1'b1);
        chk(!stuck && !pending[2], "R9 accept clears stuck", {stuck, pending[2]}, 0);
        pin_in = '0;
        drain();

        // R10 request during a pass is latched
        do_reset();
        cfg_mask[0] = 1'b0;
        @(negedge clk);
        pin_in[0] = 1'b1;
        wait_msg(got);
        kick_scan();
        chk(msg_valid, "R10 message still held", msg_valid, 1);
        respond(1'b0);
        wait_msg(got);
        chk(got && msg_pin == 5'd0, "R10 second pass redelivers", {got, msg_pin}, {1'b1, 5'd0});
        respond(1'b1);
        chk(!pending[0], "R10 delivered on second pass", pending[0], 0);
        pin_in = '0;
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule